// File: doc/BRIEF.md
# Multicast hash address filter

This block looks at the destination address at the head of a received frame and decides whether the frame is kept. The address arrives one byte per clock, with a marker on its first byte. While the bytes stream in, the block runs the Ethernet CRC-32 over them. The top six bits of that CRC pick one bit of a 64-bit hash table. A multicast destination can pass through that table. A unicast destination has to match the station address exactly. Promiscuous and pass-all-multicast modes widen what is accepted, and broadcast frames can be turned off.

Software sets the mode bits, the station address and the two 32-bit halves of the hash table through a simple register port. One clock after the sixth address byte, the block raises a single-cycle valid strobe. With that strobe it gives the accept flag and a flag that tells whether the destination was a group (multicast) address. Frame storage and any parsing after the address belong to other blocks.

Top module: `mhf_filter_top`

## Requirements
- R1: During and just after a synchronous reset, all registers read zero and `dec_valid`, `dec_accept` and `dec_mcast` are low.
- R2: Register map, selected by `reg_addr`:
  - 0 is mode. Bit 0 is promiscuous, bit 1 is pass-all-multicast, bit 2 is hash enable and bit 3 is broadcast disable. Bits 31:4 read zero.
  - 1 holds address bytes 0..3, with byte 0 in bits 7:0.
  - 2 holds bytes 4..5 in bits 15:0. Bits 31:16 read zero.
  - 3 is the low hash word and 4 is the high hash word.

  `reg_rdata` shows the register that `reg_addr` selected at the previous clock edge, with the value it had before any write at that edge.
- R3: A byte with `byte_first` high starts an address as byte 0. The next five valid bytes complete it. `dec_valid` is high for exactly one cycle, the cycle after the sixth byte. Bytes that come after the sixth byte, or before any start marker, are ignored. When `dec_valid` is low, `dec_accept` and `dec_mcast` are low.
- R4: The hash index is bits 31:26 of a CRC-32 register. The register starts at all ones and uses polynomial 0x04C11DB7, shifted MSB-first. Each address byte is fed LSB first, in byte order. The register is not inverted at the end.
- R5: Index bit 5 selects the high hash word (1) or the low hash word (0). Index bits 4:0 select the bit within that word. A set bit passes a multicast frame in hash mode.
- R6: With promiscuous set, every address is accepted.
- R7: With pass-all-multicast set, every multicast address is accepted, whatever the hash table holds.
- R8: In hash mode, a unicast address is accepted only if it equals the station address. A multicast address goes through the hash table.
- R9: With the three mode bits 0..2 cleared, only a unicast address equal to the station address is accepted. Multicast addresses other than broadcast are rejected.
- R10: An address is multicast when bit 0 of byte 0 is 1, and `dec_mcast` reports exactly this. The all-ones broadcast address is accepted unless broadcast disable is set, in which case it is rejected (promiscuous still wins).
- R11: A register write at the same edge that completes an address does not affect that decision. It applies from the next address on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wen | input | 1 | register write enable |
| reg_addr | input | 3 | register select for write and read |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | registered read data |
| byte_valid | input | 1 | address byte present |
| byte_first | input | 1 | marks byte 0 of an address |
| byte_data | input | 8 | address byte |
| dec_valid | output | 1 | one-cycle decision strobe |
| dec_accept | output | 1 | frame accepted |
| dec_mcast | output | 1 | destination is a group address |

## Verification
A register write and an address decision can land on the same clock edge. The case that matters most is a mode or hash-table write issued together with the sixth address byte. The bench provokes it by flipping promiscuous mode on, and then off, in exactly that cycle. Its reference model decides with the register values held before the edge and applies the write afterwards, so the decision must follow the old setting and the next frame the new one. Read-back is checked against the same ordering, because a read at an edge that also writes must still return the old value.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [2:0] {
    SEL_MODE    = 3'd0,
    SEL_STA_LO  = 3'd1,
    SEL_STA_HI  = 3'd2,
    SEL_HASH_LO = 3'd3,
    SEL_HASH_HI = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic bcast_off;
    logic hash_en;
    logic all_mc;
    logic promisc;
  } mode_t;

  // One byte into an MSB-first CRC register, data LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
      else              r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mhf_regs.sv
module mhf_regs
  import mhf_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ADDR_BITS = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wen,
  input  logic [2:0]           sel,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  output mode_t                mode,
  output logic [ADDR_BITS-1:0] station,
  output logic [REG_W-1:0]     hash_lo,
  output logic [REG_W-1:0]     hash_hi
);
  localparam int HI_W = ADDR_BITS - REG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= '0;
      station <= '0;
      hash_lo <= '0;
      hash_hi <= '0;
      rdata   <= '0;
    end else begin
      case (sel)
        SEL_MODE:    rdata <= REG_W'(mode);
        SEL_STA_LO:  rdata <= station[REG_W-1:0];
        SEL_STA_HI:  rdata <= REG_W'(station[ADDR_BITS-1:REG_W]);
        SEL_HASH_LO: rdata <= hash_lo;
        SEL_HASH_HI: rdata <= hash_hi;
        default:     rdata <= '0;
      endcase
      if (wen) begin
        case (sel)
          SEL_MODE:    mode <= mode_t'(wdata[$bits(mode_t)-1:0]);
          SEL_STA_LO:  station[REG_W-1:0] <= wdata;
          SEL_STA_HI:  station[ADDR_BITS-1:REG_W] <= wdata[HI_W-1:0];
          SEL_HASH_LO: hash_lo <= wdata;
          SEL_HASH_HI: hash_hi <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mhf_capture.sv
module mhf_capture
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HIDX_W     = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_valid,
  input  logic                    byte_first,
  input  logic [7:0]              byte_data,
  output logic                    last,
  output logic [ADDR_BYTES*8-1:0] addr_full,
  output logic [HIDX_W-1:0]       hidx
);
  localparam int CNT_W = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0]        cnt_q, idx;
  logic [31:0]             crc_q, crc_base, crc_nxt;
  logic [ADDR_BYTES*8-1:0] addr_q;
  logic                    take;

  assign idx      = byte_first ? '0 : cnt_q;
  assign take     = byte_valid && (byte_first || cnt_q < CNT_W'(ADDR_BYTES));
  assign crc_base = byte_first ? '1 : crc_q;
  assign crc_nxt  = crc_step(crc_base, byte_data);
  assign last     = take && (idx == CNT_W'(ADDR_BYTES - 1));
  assign hidx     = crc_nxt[31 -: HIDX_W];

  always_comb begin
    addr_full = addr_q;
    addr_full[int'(idx)*8 +: 8] = byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_W'(ADDR_BYTES);
      crc_q  <= '1;
      addr_q <= '0;
    end else if (take) begin
      cnt_q  <= idx + 1'b1;
      crc_q  <= crc_nxt;
      addr_q <= addr_full;
    end
  end
endmodule

// File: rtl/mhf_decide.sv
module mhf_decide
  import mhf_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int ADDR_BITS = 48,
  parameter int HIDX_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 last,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [HIDX_W-1:0]    hidx,
  input  mode_t                mode,
  input  logic [ADDR_BITS-1:0] station,
  input  logic [REG_W-1:0]     hash_lo,
  input  logic [REG_W-1:0]     hash_hi,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output logic                 dec_mcast
);
  logic [REG_W-1:0] word;
  logic             hbit, is_mc, is_bc, uc_hit, acc;

  assign word   = hidx[HIDX_W-1] ? hash_hi : hash_lo;
  assign hbit   = word[hidx[HIDX_W-2:0]];
  assign is_mc  = addr[0];
  assign is_bc  = &addr;
  assign uc_hit = (addr == station);
  assign acc    = mode.promisc
               | (is_bc & ~mode.bcast_off)
               | (is_mc & ~is_bc & (mode.all_mc | (mode.hash_en & hbit)))
               | (~is_mc & uc_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_mcast  <= 1'b0;
    end else begin
      dec_valid  <= last;
      dec_accept <= last & acc;
      dec_mcast  <= last & is_mc;
    end
  end
endmodule

// File: rtl/mhf_filter_top.sv
module mhf_filter_top
  import mhf_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int ADDR_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wen,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             byte_valid,
  input  logic             byte_first,
  input  logic [7:0]       byte_data,
  output logic             dec_valid,
  output logic             dec_accept,
  output logic             dec_mcast
);
  localparam int ADDR_BITS = ADDR_BYTES * 8;
  localparam int HIDX_W    = $clog2(2 * REG_W);

  mode_t                mode;
  logic [ADDR_BITS-1:0] station, addr_full;
  logic [REG_W-1:0]     hash_lo, hash_hi;
  logic [HIDX_W-1:0]    hidx;
  logic                 last;

  mhf_regs #(.REG_W(REG_W), .ADDR_BITS(ADDR_BITS)) regs_i (
    .clk(clk), .rst(rst), .wen(reg_wen), .sel(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .mode(mode), .station(station),
    .hash_lo(hash_lo), .hash_hi(hash_hi)
  );

  mhf_capture #(.ADDR_BYTES(ADDR_BYTES), .HIDX_W(HIDX_W)) cap_i (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_first(byte_first),
    .byte_data(byte_data), .last(last), .addr_full(addr_full), .hidx(hidx)
  );

  mhf_decide #(.REG_W(REG_W), .ADDR_BITS(ADDR_BITS), .HIDX_W(HIDX_W)) dec_i (
    .clk(clk), .rst(rst), .last(last), .addr(addr_full), .hidx(hidx),
    .mode(mode), .station(station), .hash_lo(hash_lo), .hash_hi(hash_hi),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_mcast(dec_mcast)
  );
endmodule

// File: rtl/mhf_filter_chk.sv
module mhf_filter_chk (
  input logic clk,
  input logic rst,
  input logic byte_valid,
  input logic dec_valid,
  input logic dec_accept,
  input logic dec_mcast,
  input logic promisc
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dec_valid);
  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  // R3
  idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && !dec_mcast));
  // R3
  strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(byte_valid));
  // R6
  promisc_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(promisc)) |-> dec_accept);
endmodule

bind mhf_filter_top mhf_filter_chk chk_i (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .dec_valid(dec_valid),
  .dec_accept(dec_accept), .dec_mcast(dec_mcast), .promisc(mode.promisc)
);

// File: tb/mhf_filter_top_tb_top.sv
module mhf_filter_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        byte_valid = 1'b0, byte_first = 1'b0;
  logic [7:0]  byte_data = 8'd0;
  logic        dec_valid, dec_accept, dec_mcast;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mhf_filter_top dut_i (
    .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .byte_valid(byte_valid),
    .byte_first(byte_first), .byte_data(byte_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_mcast(dec_mcast)
  );

  // ---------------- reference model ----------------
  logic [3:0]  m_mode;
  logic [47:0] m_sta;
  logic [31:0] m_hlo, m_hhi;
  logic [7:0]  q[$];
  bit          m_open = 0, started = 0;
  logic        e_valid = 0, e_acc = 0, e_mc = 0;
  logic [31:0] e_rdata = 0;
  string       e_tag = "R1";

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++)
      for (int k = 0; k < 8; k++) begin
        logic fb = c[31] ^ a[b*8 + k];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c[31:26];
  endfunction

  function automatic logic [31:0] ref_read(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, m_mode};
      3'd1: return m_sta[31:0];
      3'd2: return {16'd0, m_sta[47:32]};
      3'd3: return m_hlo;
      3'd4: return m_hhi;
      default: return 32'd0;
    endcase
  endfunction

  task automatic ref_decide();
    logic [47:0] a;
    logic [5:0]  hx;
    for (int i = 0; i < 6; i++) a[i*8 +: 8] = q[i];
    hx = ref_index(a);
    e_valid = 1;
    e_mc = a[0];
    if (m_mode[0])               begin e_acc = 1;            e_tag = "R6"; end
    else if (a == 48'hFFFF_FFFF_FFFF) begin e_acc = !m_mode[3]; e_tag = "R10"; end
    else if (a[0]) begin
      if (m_mode[1])             begin e_acc = 1;            e_tag = "R7"; end
      else if (m_mode[2])        begin e_acc = hx[5] ? m_hhi[hx[4:0]] : m_hlo[hx[4:0]]; e_tag = "R4 R5 R8"; end
      else                       begin e_acc = 0;            e_tag = "R9"; end
    end else begin
      e_acc = (a == m_sta);
      e_tag = m_mode[2] ? "R8" : "R9";
    end
  endtask

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_mode = 0; m_sta = 0; m_hlo = 0; m_hhi = 0;
      q.delete(); m_open = 0;
      e_valid = 0; e_acc = 0; e_mc = 0; e_rdata = 0; e_tag = "R1";
    end else begin
      e_rdata = ref_read(reg_addr);
      e_valid = 0; e_acc = 0; e_mc = 0; e_tag = "R3";
      if (byte_valid) begin
        if (byte_first) begin q.delete(); m_open = 1; end
        if (m_open && q.size() < 6) begin
          q.push_back(byte_data);
          if (q.size() == 6) begin ref_decide(); m_open = 0; end
        end
      end
      if (reg_wen) begin
        if (e_valid) e_tag = "R11";
        case (reg_addr)
          3'd0: m_mode = reg_wdata[3:0];
          3'd1: m_sta[31:0] = reg_wdata;
          3'd2: m_sta[47:32] = reg_wdata[15:0];
          3'd3: m_hlo = reg_wdata;
          3'd4: m_hhi = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if ({dec_valid, dec_accept, dec_mcast} !== {e_valid, e_acc, e_mc}) begin
        errors++;
        $display("FAIL %s: valid/accept/mcast actual %b%b%b expected %b%b%b at %0t",
                 e_tag, dec_valid, dec_accept, dec_mcast, e_valid, e_acc, e_mc, $time);
      end
      checks++;
      if (reg_rdata !== e_rdata) begin
        errors++;
        $display("FAIL %s: reg_rdata actual %h expected %h at %0t",
                 rst ? "R1" : "R2", reg_rdata, e_rdata, $time);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input logic bv, input logic bf, input logic [7:0] bd,
                      input logic we, input logic [2:0] wa, input logic [31:0] wd);
    @(negedge clk); #1;
    byte_valid = bv; byte_first = bf; byte_data = bd;
    reg_wen = we; reg_addr = wa; reg_wdata = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h00, 0, reg_addr, 0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(0, 0, 8'h00, 1, a, d);
  endtask

  // Sends six bytes; optional write in the sixth-byte cycle (R11 case).
  task automatic send(input logic [47:0] a, input bit wlast = 0,
                      input logic [2:0] wa = 0, input logic [31:0] wd = 0);
    for (int i = 0; i < 6; i++)
      step(1, i == 0, a[i*8 +: 8], wlast && i == 5, wlast && i == 5 ? wa : reg_addr, wd);
    idle(1);
  endtask

  localparam logic [47:0] STA   = 48'h5544_3322_1102;
  localparam logic [47:0] OTHER = 48'h0000_00EF_BE0A;
  localparam logic [47:0] MC    = 48'h0100_005E_0001;
  localparam logic [47:0] BC    = 48'hFFFF_FFFF_FFFF;

  initial begin
    logic [5:0] hx;
    repeat (3) @(negedge clk);
    #1 rst = 0;
    idle(2);
    // R2 writes and read-back of every register
    wr(3'd1, STA[31:0]); wr(3'd2, 32'hABCD_0000 | STA[47:32]);
    wr(3'd3, 32'h1234_5678); wr(3'd4, 32'h9ABC_DEF0); wr(3'd0, 32'hFFFF_FFF0);
    for (int r = 0; r < 6; r++) step(0, 0, 0, 0, r[2:0], 0);
    idle(2);
    wr(3'd3, 0); wr(3'd4, 0);
    // R9 all modes off
    send(STA); send(OTHER); send(MC);
    // R10 broadcast on and off
    send(BC); wr(3'd0, 32'h8); send(BC); wr(3'd0, 0);
    // R4 R5 R8 hash mode
    hx = ref_index(MC);
    wr(3'd0, 32'h4);
    if (hx[5]) wr(3'd4, 32'h1 << hx[4:0]); else wr(3'd3, 32'h1 << hx[4:0]);
    send(MC); send(STA); send(OTHER);
    if (hx[5]) begin wr(3'd4, ~(32'h1 << hx[4:0])); wr(3'd3, '1); end
    else       begin wr(3'd3, ~(32'h1 << hx[4:0])); wr(3'd4, '1); end
    send(MC);
    wr(3'd3, 0); wr(3'd4, 0);
    // R7 pass-all-multicast
    wr(3'd0, 32'h6); send(MC); send(OTHER); send(48'h3300_0000_0001);
    // R6 promiscuous
    wr(3'd0, 32'h9); send(OTHER); send(BC); send(MC);
    // R3 bytes before a start marker and after the sixth byte are ignored
    wr(3'd0, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 8'h55, 0, 0, 0);
    for (int i = 0; i < 9; i++) step(1, i == 0, i < 6 ? STA[i*8 +: 8] : 8'h77, 0, 0, 0);
    idle(2);
    // R3 restart mid-address, then back-to-back frames
    for (int i = 0; i < 3; i++) step(1, i == 0, OTHER[i*8 +: 8], 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, i == 0, STA[i*8 +: 8], 0, 0, 0);
    for (int i = 0; i < 6; i++) step(1, i == 0, MC[i*8 +: 8], 0, 0, 0);
    idle(2);
    // R11 write in the deciding cycle
    send(OTHER, 1, 3'd0, 32'h1); send(OTHER);
    send(OTHER, 1, 3'd0, 32'h0); send(OTHER);
    // mixed random traffic and modes
    for (int n = 0; n < 60; n++) begin
      logic [47:0] a;
      a = {$urandom, $urandom};
      case (n % 4)
        0: a = STA;
        1: a[0] = 1'b1;
        default: ;
      endcase
      if (n % 7 == 0) wr(3'd0, $urandom & 32'hF);
      if (n % 5 == 0) wr(3'd3, $urandom);
      if (n % 5 == 1) wr(3'd4, $urandom);
      send(a, n % 9 == 0, 3'd0, $urandom & 32'hF);
    end
    idle(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule